// File: doc/BRIEF.md
# Multi-channel slave DMA controller

This block is a six-channel DMA engine that moves data between a peripheral data port and memory on behalf of software. Software programs each channel through a 32-bit register port. The per-channel settings are the source and destination addresses, a count of transfer units, a request selector and a command word. Software then sets the channel's enable bit and the global enable bit. The engine serves the channels that are ready in a fixed round-robin order, one unit per grant, through a single memory-side request port that reads a beat and then writes it.

The count is held in transfer units, not bytes. A unit is 1, 2, 4, 16 or 32 bytes long, and units longer than a word are moved as a run of 4-byte beats. Each channel can be paced by a peripheral request line or can run freely. In single mode it moves one unit per request. In block mode it moves its whole count after one request. When the count reaches zero the channel stops itself and flags completion. If software has enabled the interrupt, the channel also raises a pending bit that drives the shared interrupt line.

Top module: `dma_slave_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: Each channel has a 0x20-byte window at channel×0x20, with these offsets: source address 0x00, destination address 0x04, unit count 0x08, request selector 0x0C, status 0x10, command 0x14. The global control register is at 0x300 and the pending register is at 0x304. Every other offset reads zero and ignores writes, and writes to 0x304 are ignored.
- R3: Command bits 10:8 give the unit size: 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes and 4 is 32 bytes. A 16-byte or 32-byte unit moves as 4 or 8 beats of 4 bytes. Each beat reads the source address and then writes that data to the destination address, and `mem_bytes` gives the beat size.
- R4: Command bit 23 makes the source address advance by the beat size after each beat, and bit 22 does the same for the destination address. When a bit is clear, that address stays fixed.
- R5: The count register holds units, and reading it back returns the units not yet completed.
- R6: When the last unit completes, the channel clears status bit 0 (enable) and sets status bit 3 (done) and bit 1 (count end). Its address registers keep their final advanced values.
- R7: When a channel completes with command bit 1 set, pending bit i at 0x304 goes high, and `irq` is the OR of the pending bits. A status write that clears bit 3 also clears that channel's pending bit. Software writes can clear status bits 1, 3 and 4 but cannot set them.
- R8: A channel is granted only when status bit 0 and global control bit 0 are both set and status bit 2 and global control bit 3 (halt) are both clear.
- R9: A selector value of 0 to 7 ties the channel to line `periph_req[sel]`, and the value 8 means the channel needs no request. With command bit 7 clear, the channel moves one unit per rising edge of its line. With bit 7 set, one rising edge moves the whole count.
- R10: Command bits 15:14 give the source width and bits 13:12 give the destination width: 0 is 4 bytes, 1 is 1 byte and 2 is 2 bytes. If an address is not aligned to its width at grant time, the channel sets status bits 4 and 2 and moves nothing.
- R11: Ready channels are granted one unit at a time. The search for the next grant starts at the channel after the one granted last.
- R12: While `mem_req` is high and `mem_ack` is low, the request, its direction, its address and its write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| periph_req | input | 8 | Peripheral request lines |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_bytes | output | 3 | Beat size in bytes (1, 2 or 4) |
| mem_ack | input | 1 | Memory beat accepted / read data valid |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Combined completion interrupt |

## Verification
The main transfer path is run with a free-running word copy that advances both addresses, and with a request-paced halfword copy from a fixed source address, which separates the two increment bits and shows the count being read back between units. A block-mode 16-byte copy started by a single request edge checks the beat splitting and the single-versus-block pacing. Each gate (global halt, global disable, channel halt, misalignment) is held in turn against a pending job to show that it alone stops the engine. A simultaneous start of two channels, made right after a known last grant, fixes the round-robin order, and a held-off acknowledge checks that a request stays stable while it waits.

// File: rtl/dma_slave_ctrl.sv
module dma_slave_ctrl #(
  parameter int NCH      = 6,
  parameter int NREQ     = 8,
  parameter int AUTO_SEL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [9:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [NREQ-1:0] periph_req,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [2:0]  mem_bytes,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int RW = $clog2(NREQ);
  localparam logic [31:0] CMD_MASK = 32'h00C0_F782;

  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_t;

  logic [31:0] src_q [NCH];
  logic [31:0] dst_q [NCH];
  logic [31:0] cnt_q [NCH];
  logic [31:0] cmd_q [NCH];
  logic [4:0]  sel_q [NCH];
  logic [NCH-1:0] s_en, s_term, s_halt, s_done, s_aerr, s_inv, s_nod;
  logic [NCH-1:0] pend, armed, reqq, sel_req, ready;
  logic       g_en, g_aerr, g_halt;
  logic [1:0] g_prio;

  eng_t       st;
  logic [2:0] act_ch, last_ch, gnt_ch;
  logic       gnt_valid;
  logic [3:0] beats_left;
  logic [31:0] addr_q, data_q;

  function automatic logic [2:0] beat_of(input logic [2:0] sz);
    case (sz)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] nbeats_of(input logic [2:0] sz);
    case (sz)
      3'd3:    return 4'd4;
      3'd4:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic aligned(input logic [31:0] a, input logic [1:0] w);
    case (w)
      2'd0:    return a[1:0] == 2'b00;
      2'd2:    return a[0] == 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  wire [2:0] ch_sel  = reg_addr[7:5];
  wire [4:0] off     = reg_addr[4:0];
  wire       chan_hit = (reg_addr[9:8] == 2'b00) && (int'(ch_sel) < NCH);
  wire       ctl_hit  = (reg_addr[9:8] == 2'b11) && (reg_addr[7:0] == 8'h00);
  wire       pnd_hit  = (reg_addr[9:8] == 2'b11) && (reg_addr[7:0] == 8'h04);

  always_comb begin
    reg_rdata = '0;
    if (chan_hit) begin
      case (off)
        5'h00: reg_rdata = src_q[ch_sel];
        5'h04: reg_rdata = dst_q[ch_sel];
        5'h08: reg_rdata = cnt_q[ch_sel];
        5'h0C: reg_rdata = {27'b0, sel_q[ch_sel]};
        5'h10: reg_rdata = {s_nod[ch_sel], 24'b0, s_inv[ch_sel], 1'b0, s_aerr[ch_sel],
                            s_done[ch_sel], s_halt[ch_sel], s_term[ch_sel], s_en[ch_sel]};
        5'h14: reg_rdata = cmd_q[ch_sel];
        default: reg_rdata = '0;
      endcase
    end else if (ctl_hit) begin
      reg_rdata = {22'b0, g_prio, 4'b0, g_halt, g_aerr, 1'b0, g_en};
    end else if (pnd_hit) begin
      reg_rdata = {{(32-NCH){1'b0}}, pend};
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (int'(sel_q[i]) == AUTO_SEL) sel_req[i] = 1'b1;
      else if (int'(sel_q[i]) < NREQ) sel_req[i] = periph_req[sel_q[i][RW-1:0]];
      else sel_req[i] = 1'b0;
      ready[i] = s_en[i] && g_en && !s_halt[i] && !g_halt && (cnt_q[i] != 0) &&
                 ((int'(sel_q[i]) == AUTO_SEL) || armed[i]);
    end
  end

  always_comb begin
    int idx;
    gnt_valid = 1'b0;
    gnt_ch    = '0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(last_ch) + k) % NCH;
      if (!gnt_valid && ready[idx]) begin
        gnt_valid = 1'b1;
        gnt_ch    = 3'(idx);
      end
    end
  end

  wire [2:0]  act_beat = beat_of(cmd_q[act_ch][10:8]);
  wire [31:0] nxt_src  = cmd_q[act_ch][23] ? src_q[act_ch] + {29'b0, act_beat} : src_q[act_ch];
  wire [31:0] nxt_dst  = cmd_q[act_ch][22] ? dst_q[act_ch] + {29'b0, act_beat} : dst_q[act_ch];
  wire        gnt_ok   = aligned(src_q[gnt_ch], cmd_q[gnt_ch][15:14]) &&
                         aligned(dst_q[gnt_ch], cmd_q[gnt_ch][13:12]);

  assign mem_req   = (st != E_IDLE);
  assign mem_we    = (st == E_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_bytes = act_beat;
  assign irq       = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0; dst_q[i] <= '0; cnt_q[i] <= '0; cmd_q[i] <= '0; sel_q[i] <= '0;
      end
      {s_en, s_term, s_halt, s_done, s_aerr, s_inv, s_nod} <= '0;
      pend <= '0; armed <= '0; reqq <= '0;
      g_en <= 1'b0; g_aerr <= 1'b0; g_halt <= 1'b0; g_prio <= '0;
      st <= E_IDLE; act_ch <= '0; last_ch <= 3'(NCH-1);
      beats_left <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      reqq <= sel_req;
      for (int i = 0; i < NCH; i++) begin
        if (!s_en[i]) armed[i] <= 1'b0;
        else if (sel_req[i] && !reqq[i]) armed[i] <= 1'b1;
      end

      if (reg_we && chan_hit) begin
        case (off)
          5'h00: src_q[ch_sel] <= reg_wdata;
          5'h04: dst_q[ch_sel] <= reg_wdata;
          5'h08: cnt_q[ch_sel] <= reg_wdata;
          5'h0C: sel_q[ch_sel] <= reg_wdata[4:0];
          5'h10: begin
            s_en[ch_sel]   <= reg_wdata[0];
            s_term[ch_sel] <= s_term[ch_sel] & reg_wdata[1];
            s_halt[ch_sel] <= reg_wdata[2];
            s_done[ch_sel] <= s_done[ch_sel] & reg_wdata[3];
            s_aerr[ch_sel] <= s_aerr[ch_sel] & reg_wdata[4];
            s_inv[ch_sel]  <= reg_wdata[6];
            s_nod[ch_sel]  <= reg_wdata[31];
            if (!reg_wdata[3]) pend[ch_sel] <= 1'b0;
          end
          5'h14: cmd_q[ch_sel] <= reg_wdata & CMD_MASK;
          default: ;
        endcase
      end
      if (reg_we && ctl_hit) begin
        g_en   <= reg_wdata[0];
        g_aerr <= reg_wdata[2];
        g_halt <= reg_wdata[3];
        g_prio <= reg_wdata[9:8];
      end

      case (st)
        E_IDLE: if (gnt_valid) begin
          last_ch <= gnt_ch;
          act_ch  <= gnt_ch;
          if (gnt_ok) begin
            beats_left <= nbeats_of(cmd_q[gnt_ch][10:8]);
            addr_q     <= src_q[gnt_ch];
            st         <= E_RD;
          end else begin
            s_aerr[gnt_ch] <= 1'b1;
            s_halt[gnt_ch] <= 1'b1;
          end
        end
        E_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          addr_q <= dst_q[act_ch];
          st     <= E_WR;
        end
        E_WR: if (mem_ack) begin
          src_q[act_ch] <= nxt_src;
          dst_q[act_ch] <= nxt_dst;
          if (beats_left == 4'd1) begin
            cnt_q[act_ch] <= cnt_q[act_ch] - 32'd1;
            if (!cmd_q[act_ch][7]) armed[act_ch] <= 1'b0;
            if (cnt_q[act_ch] == 32'd1) begin
              s_en[act_ch]   <= 1'b0;
              s_done[act_ch] <= 1'b1;
              s_term[act_ch] <= 1'b1;
              armed[act_ch]  <= 1'b0;
              if (cmd_q[act_ch][1]) pend[act_ch] <= 1'b1;
            end
            st <= E_IDLE;
          end else begin
            beats_left <= beats_left - 4'd1;
            addr_q     <= nxt_src;
            st         <= E_RD;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_pend_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |-> s_done[i]);
    p_done_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_done[i]) |-> cnt_q[i] == 32'd0);
  end

  p_hold_while_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_start_needs_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(g_en && !g_halt));

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !mem_req && !irq);
endmodule

// File: tb/dma_slave_ctrl_bench.sv
`timescale 1ns/1ps
module dma_slave_ctrl_bench;
  localparam logic [31:0] K = 32'h5A5A_0000;
  localparam logic [31:0] SINC = 32'h0080_0000, DINC = 32'h0040_0000;
  localparam logic [31:0] BLK = 32'h80, IE = 32'h2;

  logic        clk = 0, rst_n = 0, reg_we = 0, mem_ack = 1;
  logic [9:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0]  periph_req = 0;
  logic [31:0] reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, irq;
  logic [2:0]  mem_bytes;
  int tests = 0, fails = 0;
  logic [66:0] exp_q[$];

  assign mem_rdata = mem_addr ^ K;

  dma_slave_ctrl u_dma_slave_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_bytes(mem_bytes), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    logic [66:0] e;
    if (rst_n && mem_req && mem_we && mem_ack) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3: unexpected write got %h expected none", {mem_bytes, mem_addr, mem_wdata});
      end else begin
        e = exp_q.pop_front();
        if ({mem_bytes, mem_addr, mem_wdata} !== e) begin
          fails++;
          $display("FAIL R3/R4 beat: got %h expected %h", {mem_bytes, mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic push(input logic [2:0] b, input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({b, a, d});
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(tag, exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); periph_req[line] = 1'b1;
    repeat (2) @(negedge clk); periph_req[line] = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] n, input logic [31:0] sel, input logic [31:0] cmd);
    wr(10'(ch*32 + 0), s);  wr(10'(ch*32 + 4), d);
    wr(10'(ch*32 + 8), n);  wr(10'(ch*32 + 12), sel);
    wr(10'(ch*32 + 20), cmd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 status", 10'h010, 0);
    rd_chk("R1 count", 10'h028, 0);
    rd_chk("R1 ctrl", 10'h300, 0);
    rd_chk("R1 pending", 10'h304, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);

    // word copy, both addresses advance, free-running
    setup(0, 32'h1000, 32'h2000, 3, 8, SINC | DINC | IE);
    for (int k = 0; k < 3; k++) push(3'd4, 32'h2000 + 32'(4*k), (32'h1000 + 32'(4*k)) ^ K);
    wr(10'h010, 1); wr(10'h300, 1);
    drain("R3 word copy");
    rd_chk("R6 status done", 10'h010, 32'h0A);
    rd_chk("R5 count zero", 10'h008, 0);
    rd_chk("R6 src final", 10'h000, 32'h100C);
    rd_chk("R6 dst final", 10'h004, 32'h200C);
    rd_chk("R7 pending", 10'h304, 32'h1);
    chk("R7 irq high", {31'b0, irq}, 1);
    wr(10'h010, 0);
    rd_chk("R7 pending cleared", 10'h304, 0);
    chk("R7 irq low", {31'b0, irq}, 0);
    wr(10'h010, 32'h1A);
    rd_chk("R7 sw cannot set flags", 10'h010, 0);

    // request-paced halfword copy, fixed source
    setup(1, 32'h4000, 32'h5000, 2, 3, DINC | (2 << 14) | (2 << 12) | (2 << 8));
    wr(10'h030, 1);
    repeat (20) @(negedge clk);
    rd_chk("R9 no request no move", 10'h028, 2);
    push(3'd2, 32'h5000, 32'h4000 ^ K);
    pulse(3);
    drain("R9 single unit");
    rd_chk("R5 remaining", 10'h028, 1);
    push(3'd2, 32'h5002, 32'h4000 ^ K);
    pulse(3);
    drain("R9 second unit");
    rd_chk("R6 single done", 10'h030, 32'h0A);
    rd_chk("R4 src fixed", 10'h020, 32'h4000);
    rd_chk("R4 dst advanced", 10'h024, 32'h5004);

    // block mode, 16-byte units, one request edge
    wr(10'h030, 0);
    setup(1, 32'h6000, 32'h7000, 2, 5, SINC | DINC | BLK | (3 << 8));
    for (int k = 0; k < 8; k++) push(3'd4, 32'h7000 + 32'(4*k), (32'h6000 + 32'(4*k)) ^ K);
    wr(10'h030, 1);
    pulse(5);
    drain("R3 R9 block 16B");
    rd_chk("R9 block count", 10'h028, 0);
    rd_chk("R6 block done", 10'h030, 32'h0A);

    // gating
    setup(0, 32'h8001, 32'h9003, 1, 8, (1 << 14) | (1 << 12) | (1 << 8));
    wr(10'h300, 32'h9);
    wr(10'h010, 1);
    repeat (20) @(negedge clk);
    rd_chk("R8 global halt", 10'h008, 1);
    wr(10'h300, 0);
    repeat (20) @(negedge clk);
    rd_chk("R8 global disable", 10'h008, 1);
    wr(10'h010, 32'h5);
    wr(10'h300, 1);
    repeat (20) @(negedge clk);
    rd_chk("R8 channel halt", 10'h008, 1);
    push(3'd1, 32'h9003, 32'h8001 ^ K);
    wr(10'h010, 1);
    drain("R8 released");
    rd_chk("R8 count after", 10'h008, 0);

    // unmapped offsets
    wr(10'h018, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped chan", 10'h018, 0);
    wr(10'h308, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped global", 10'h308, 0);
    wr(10'h304, 32'h3F);
    rd_chk("R2 pending not writable", 10'h304, 0);

    // misaligned source on channel 5
    setup(5, 32'h0A02, 32'hB000, 1, 8, SINC | DINC);
    wr(10'h0B0, 1);
    repeat (20) @(negedge clk);
    rd_chk("R10 misaligned status", 10'h0B0, 32'h15);
    rd_chk("R10 misaligned count", 10'h0A8, 1);

    // round-robin between channels 2 and 4
    wr(10'h300, 0);
    setup(2, 32'hC000, 32'hD000, 2, 8, SINC | DINC);
    setup(4, 32'hE000, 32'hF000, 2, 8, SINC | DINC);
    wr(10'h050, 1); wr(10'h090, 1);
    push(3'd4, 32'hD000, 32'hC000 ^ K);
    push(3'd4, 32'hF000, 32'hE000 ^ K);
    push(3'd4, 32'hD004, 32'hC004 ^ K);
    push(3'd4, 32'hF004, 32'hE004 ^ K);
    wr(10'h300, 1);
    drain("R11 round robin");

    // stalled acknowledge
    mem_ack = 0;
    setup(3, 32'h0300, 32'h0400, 1, 8, 0);
    wr(10'h070, 1);
    repeat (10) @(negedge clk);
    chk("R12 req held", {31'b0, mem_req}, 1);
    chk("R12 read dir", {31'b0, mem_we}, 0);
    chk("R12 addr held", mem_addr, 32'h0300);
    rd_chk("R5 count while stalled", 10'h068, 1);
    push(3'd4, 32'h0400, 32'h0300 ^ K);
    @(negedge clk); mem_ack = 1;
    drain("R12 stall release");
    rd_chk("R6 stalled done", 10'h070, 32'h0A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule